// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Port

This block holds the colour map of a framebuffer. It has 256 pixel colours and a separate bank of 4 overlay colours that a cursor uses. Software reaches it through a 32-bit register port. It first writes an entry number. It then moves red, green and blue bytes one at a time, in either direction. A single two-bit phase counter sequences the components for both reads and writes. After the blue byte the counter steps the entry number forward, so a whole run of consecutive colours can be loaded or read back with one index write.

The display side has two combinational lookup ports. One maps an 8-bit pixel value to a 24-bit RGB word. The other maps a 2-bit overlay select to a 24-bit RGB word. A write shows up on these ports as soon as the clock edge that stores it has passed. Register reads respond one cycle after the request, on a registered data port.

Top module: `clut_regport`

## Requirements
- R1: After reset, every pixel entry reads as 24'h000000 on the lookup port except entry 255, which is 24'hFFFFFF. Overlay entries 0 and 2 are 24'hFFFFFF and overlay entries 1 and 3 are zero. The entry number and the phase are both zero, so the first component accessed is the red byte of entry 0.
- R2: A full write to byte offset 0x0 loads the entry number from data bits 31:24 and returns the phase to red.
- R3: Full writes to offset 0x4 store data bits 31:24 into the current pixel entry, as red, then green, then blue, on successive writes. Lookup RGB is packed red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The new value appears on the lookup port in the cycle after the write.
- R4: After the blue component is accessed, the entry number increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: Full writes to offset 0xC store into overlay entry (entry number mod 4) with the same red/green/blue sequence. They leave the pixel bank untouched, and they also step the entry number after blue.
- R6: A full read returns the current component in bits 31:24, with bits 23:0 zero, and asserts the response valid for one cycle, one cycle after the request. Reads at offset 0xC read the overlay entry. Reads at any other offset read the pixel entry. Reads advance the same phase counter and index that writes use.
- R7: An access whose byte enables are not all four set is ignored. It changes no entry, no entry number and no phase, and it produces no response.
- R8: Full writes to offsets other than 0x0, 0x4 and 0xC change nothing.
- R9: A two-bit phase value outside red, green and blue is never reached. Any such value returns to red on the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the register window |
| req_be | input | 4 | Byte enables; all four must be set |
| req_wdata | input | 32 | Write data; component in bits 31:24 |
| rsp_valid | output | 1 | Read data valid (one cycle after a full read) |
| rsp_rdata | output | 32 | Read data; component in bits 31:24 |
| lk_pix_idx | input | 8 | Pixel value to translate |
| lk_pix_rgb | output | 24 | Colour of that pixel entry |
| lk_ovl_sel | input | 2 | Overlay entry to translate |
| lk_ovl_rgb | output | 24 | Colour of that overlay entry |

## Verification
The bench targets these corner cases:

- **Index wrap.** The bench loads entries 254, 255 and 0 with a single index write and reads them back the same way. A design that let the index run past 255, or that forgot to step it, would store or return the wrong entry.
- **Shared phase.** It interleaves reads and writes inside one colour triple. A design with separate read and write phases would shift components by one position.
- **Overlay write while pointing high.** It writes the overlay bank while the index is large. A design that dropped the modulo would write outside the bank, corrupt pixel colours, or fail to step the index.
- **Ignored accesses.** It sends partial-width accesses and writes to unused offsets. A design that did not discard them would advance the phase, which every later access would then expose.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Component phase. CPH_SPARE is never reached; it returns to red on any step.
  typedef enum logic [1:0] {
    CPH_RED   = 2'd0,
    CPH_GRN   = 2'd1,
    CPH_BLU   = 2'd2,
    CPH_SPARE = 2'd3
  } comp_phase_e;

  // Register offsets. Decode depends on these values.
  localparam logic [3:0] OFS_INDEX = 4'h0;
  localparam logic [3:0] OFS_PIXEL = 4'h4;
  localparam logic [3:0] OFS_OVL   = 4'hC;

  localparam int NUM_COMP = 3;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,      // full-width access accepted
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] ofs,
  input  logic [IDX_W-1:0]  wr_byte,
  output logic [IDX_W-1:0]  cur_idx,
  output comp_phase_e       cur_ph,
  output logic              pix_we,
  output logic              ovl_we,
  output logic              rd_fire,
  output logic              rd_ovl
);

  logic ld_index;
  logic step;

  always_comb begin
    ld_index = acc && is_wr && (ofs == ADDR_W'(OFS_INDEX));
    pix_we   = acc && is_wr && (ofs == ADDR_W'(OFS_PIXEL));
    ovl_we   = acc && is_wr && (ofs == ADDR_W'(OFS_OVL));
    rd_fire  = acc && !is_wr;
    rd_ovl   = rd_fire && (ofs == ADDR_W'(OFS_OVL));
    step     = pix_we || ovl_we || rd_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      cur_ph  <= CPH_RED;
    end else if (ld_index) begin
      cur_idx <= wr_byte;
      cur_ph  <= CPH_RED;
    end else if (step) begin
      unique case (cur_ph)
        CPH_RED: cur_ph <= CPH_GRN;
        CPH_GRN: cur_ph <= CPH_BLU;
        CPH_BLU: begin
          cur_ph  <= CPH_RED;
          cur_idx <= cur_idx + 1'b1;
        end
        default: cur_ph <= CPH_RED;
      endcase
    end
  end

  // R9
  phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cur_ph != CPH_SPARE);

  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && is_wr && ofs == ADDR_W'(OFS_INDEX)) |=> (cur_ph == CPH_RED && cur_idx == $past(wr_byte)));

  // R4
  blue_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cur_ph == CPH_BLU) |=> (cur_ph == CPH_RED && cur_idx == $past(cur_idx) + 1'b1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(cur_idx) && $stable(cur_ph)));

endmodule

// File: rtl/clut_bank.sv
module clut_bank
  import clut_pkg::*;
#(
  parameter int           DEPTH     = 256,
  parameter int           COMP_W    = 8,
  parameter logic [DEPTH-1:0] WHITE_MAP = '0,
  localparam int          IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int          RGB_W     = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_comp,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_comp,
  output logic [COMP_W-1:0] rd_byte,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [RGB_W-1:0]  lk_rgb
);

  logic [COMP_W-1:0] rd_lane [NUM_COMP];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int e = 0; e < DEPTH; e++) begin
          store[e] <= WHITE_MAP[e] ? {COMP_W{1'b1}} : '0;
        end
      end else if (wr_en && wr_comp == 2'(c)) begin
        store[wr_idx] <= wr_byte;
      end
    end

    assign lk_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] = store[lk_idx];
    assign rd_lane[c] = store[rd_idx];
  end

  always_comb begin
    unique case (rd_comp)
      2'd0:    rd_byte = rd_lane[0];
      2'd1:    rd_byte = rd_lane[1];
      2'd2:    rd_byte = rd_lane[2];
      default: rd_byte = '0;
    endcase
  end

endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int COMP_W      = 8,
  parameter int PIX_ENTRIES = 256,
  parameter int OVL_ENTRIES = 4,
  localparam int BE_W       = DATA_W / 8,
  localparam int PIX_IDX_W  = $clog2(PIX_ENTRIES),
  localparam int OVL_IDX_W  = $clog2(OVL_ENTRIES),
  localparam int RGB_W      = NUM_COMP * COMP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BE_W-1:0]      req_be,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [PIX_IDX_W-1:0] lk_pix_idx,
  output logic [RGB_W-1:0]     lk_pix_rgb,
  input  logic [OVL_IDX_W-1:0] lk_ovl_sel,
  output logic [RGB_W-1:0]     lk_ovl_rgb
);

  localparam logic [PIX_ENTRIES-1:0] PIX_WHITE = PIX_ENTRIES'(1) << (PIX_ENTRIES - 1);
  localparam logic [OVL_ENTRIES-1:0] OVL_WHITE = OVL_ENTRIES'(5);

  logic                 acc;
  logic [COMP_W-1:0]    wr_byte;
  logic [PIX_IDX_W-1:0] cur_idx;
  comp_phase_e          cur_ph;
  logic                 pix_we, ovl_we, rd_fire, rd_ovl;
  logic [COMP_W-1:0]    pix_rd, ovl_rd;

  assign acc     = req_valid && (req_be == {BE_W{1'b1}});
  assign wr_byte = req_wdata[DATA_W-1 -: COMP_W];

  clut_seq #(.ADDR_W(ADDR_W), .IDX_W(PIX_IDX_W)) u_seq (
    .clk(clk), .rst(rst), .acc(acc), .is_wr(req_we), .ofs(req_addr),
    .wr_byte(wr_byte), .cur_idx(cur_idx), .cur_ph(cur_ph),
    .pix_we(pix_we), .ovl_we(ovl_we), .rd_fire(rd_fire), .rd_ovl(rd_ovl)
  );

  clut_bank #(.DEPTH(PIX_ENTRIES), .COMP_W(COMP_W), .WHITE_MAP(PIX_WHITE)) u_pix (
    .clk(clk), .rst(rst), .wr_en(pix_we), .wr_idx(cur_idx), .wr_comp(cur_ph),
    .wr_byte(wr_byte), .rd_idx(cur_idx), .rd_comp(cur_ph), .rd_byte(pix_rd),
    .lk_idx(lk_pix_idx), .lk_rgb(lk_pix_rgb)
  );

  clut_bank #(.DEPTH(OVL_ENTRIES), .COMP_W(COMP_W), .WHITE_MAP(OVL_WHITE)) u_ovl (
    .clk(clk), .rst(rst), .wr_en(ovl_we), .wr_idx(cur_idx[OVL_IDX_W-1:0]), .wr_comp(cur_ph),
    .wr_byte(wr_byte), .rd_idx(cur_idx[OVL_IDX_W-1:0]), .rd_comp(cur_ph), .rd_byte(ovl_rd),
    .lk_idx(lk_ovl_sel), .lk_rgb(lk_ovl_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_rdata <= {(rd_ovl ? ovl_rd : pix_rd), {(DATA_W-COMP_W){1'b0}}};
      end
    end
  end

  // R6
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_we && req_be == {BE_W{1'b1}}));

  // R7
  partial_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_be != {BE_W{1'b1}}) |=> !rsp_valid);

  // R5
  ovl_keeps_pix_chk: assert property (@(posedge clk) disable iff (rst)
    (ovl_we && lk_pix_idx == cur_idx) |=> (lk_pix_idx != $past(lk_pix_idx) || $stable(lk_pix_rgb)));

endmodule

// File: tb/clut_regport_bench.sv
module clut_regport_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_we;
  logic [3:0]  req_addr, req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  lk_pix_idx;
  logic [23:0] lk_pix_rgb;
  logic [1:0]  lk_ovl_sel;
  logic [23:0] lk_ovl_rgb;

  int vectors = 0;
  int miscompares = 0;

  // Model
  logic [7:0] m_pix [256][3];
  logic [7:0] m_ovl [4][3];
  logic [7:0] m_idx;
  int         m_ph;

  always #5 clk = ~clk;

  clut_regport u_clut_regport (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lk_pix_idx(lk_pix_idx), .lk_pix_rgb(lk_pix_rgb), .lk_ovl_sel(lk_ovl_sel),
    .lk_ovl_rgb(lk_ovl_rgb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pix_exp(input logic [7:0] i);
    return {m_pix[i][0], m_pix[i][1], m_pix[i][2]};
  endfunction

  function automatic logic [23:0] ovl_exp(input logic [1:0] i);
    return {m_ovl[i][0], m_ovl[i][1], m_ovl[i][2]};
  endfunction

  task automatic model_step();
    if (m_ph == 2) begin
      m_ph  = 0;
      m_idx = m_idx + 8'd1;
    end else begin
      m_ph = m_ph + 1;
    end
  endtask

  task automatic look(input string tag, input logic [7:0] p, input logic [1:0] o);
    lk_pix_idx = p;
    lk_ovl_sel = o;
    #1;
    check({tag, " pixel lookup"}, 32'(lk_pix_rgb), 32'(pix_exp(p)));
    check({tag, " overlay lookup"}, 32'(lk_ovl_rgb), 32'(ovl_exp(o)));
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic access(input string tag, input logic we, input logic [3:0] ofs,
                        input logic [3:0] be, input logic [31:0] d);
    logic       full;
    logic [7:0] expb;
    full = (be == 4'hF);
    expb = (ofs == 4'hC) ? m_ovl[m_idx[1:0]][m_ph] : m_pix[m_idx][m_ph];
    req_valid = 1'b1; req_we = we; req_addr = ofs; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!we && full) begin
      check({tag, " R6 rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " R6 read data"}, rsp_rdata, {expb, 24'h0});
    end else begin
      check({tag, " R7 no response"}, 32'(rsp_valid), 32'd0);
    end
    if (full) begin
      if (we && ofs == 4'h0) begin
        m_idx = d[31:24]; m_ph = 0;
      end else if (we && ofs == 4'h4) begin
        m_pix[m_idx][m_ph] = d[31:24]; model_step();
      end else if (we && ofs == 4'hC) begin
        m_ovl[m_idx[1:0]][m_ph] = d[31:24]; model_step();
      end else if (!we) begin
        model_step();
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] sel;
    logic [3:0] ofs;
    process::self().srandom(32'd1234);
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0;
    req_wdata = '0; lk_pix_idx = '0; lk_ovl_sel = '0;
    for (int e = 0; e < 256; e++) for (int c = 0; c < 3; c++) m_pix[e][c] = (e == 255) ? 8'hFF : 8'h00;
    for (int e = 0; e < 4; e++) for (int c = 0; c < 3; c++) m_ovl[e][c] = (e == 0 || e == 2) ? 8'hFF : 8'h00;
    m_idx = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset contents
    look("R1 reset", 8'd255, 2'd0);
    look("R1 reset", 8'd0, 2'd1);
    look("R1 reset", 8'd254, 2'd2);
    look("R1 reset", 8'd128, 2'd3);
    access("R1 first read red of entry 0", 1'b0, 4'h4, 4'hF, 32'h0);

    // R2 index reload mid-triple, then R3/R4 wrap across 254,255,0
    access("R2 index", 1'b1, 4'h0, 4'hF, 32'hFE00_0000);
    for (int k = 0; k < 9; k++) access("R3 load", 1'b1, 4'h4, 4'hF, {8'(8'h11 * (k + 1)), 24'hABCDEF});
    look("R4 wrap entry 0", 8'd0, 2'd0);
    look("R3 entry 255", 8'd255, 2'd1);
    access("R2 index", 1'b1, 4'h0, 4'hF, 32'hFE12_3456);
    for (int k = 0; k < 9; k++) access("R4 readback", 1'b0, 4'h4, 4'hF, 32'h0);

    // R6 shared phase: write red, read green, write blue
    access("R2 index", 1'b1, 4'h0, 4'hF, 32'h1000_0000);
    access("R6 mix", 1'b1, 4'h4, 4'hF, 32'h5A00_0000);
    access("R6 mix", 1'b0, 4'h4, 4'hF, 32'h0);
    access("R6 mix", 1'b1, 4'h4, 4'hF, 32'hA500_0000);
    look("R6 mix", 8'h10, 2'd0);

    // R5 overlay while index high
    access("R2 index", 1'b1, 4'h0, 4'hF, 32'hFF00_0000);
    for (int k = 0; k < 3; k++) access("R5 overlay", 1'b1, 4'hC, 4'hF, {8'(8'h30 + k), 24'h0});
    look("R5 overlay 3", 8'd255, 2'd3);
    look("R5 index wrapped", 8'd0, 2'd3);
    access("R5 next read entry 0", 1'b0, 4'h4, 4'hF, 32'h0);

    // R7 partial, R8 unused offsets
    access("R7 partial write", 1'b1, 4'h4, 4'h7, 32'h7700_0000);
    access("R7 partial read", 1'b0, 4'h4, 4'h1, 32'h0);
    access("R8 offset 8", 1'b1, 4'h8, 4'hF, 32'h9900_0000);
    access("R8 offset 5", 1'b1, 4'h5, 4'hF, 32'h9900_0000);
    access("R9 phase after ignored", 1'b0, 4'h4, 4'hF, 32'h0);

    // Random mix
    for (int n = 0; n < 2500; n++) begin
      sel = 8'($urandom_range(0, 99));
      if (sel < 8) begin
        access("R2 rnd index", 1'b1, 4'h0, 4'hF, {($urandom_range(0, 1) != 0) ? 8'($urandom_range(250, 255)) : 8'($urandom), 24'($urandom)});
      end else if (sel < 45) begin
        access("R3 rnd pixel write", 1'b1, 4'h4, 4'hF, $urandom);
      end else if (sel < 55) begin
        access("R5 rnd overlay write", 1'b1, 4'hC, 4'hF, $urandom);
      end else if (sel < 85) begin
        ofs = ($urandom_range(0, 3) == 0) ? 4'hC : 4'($urandom_range(0, 15));
        access("R6 rnd read", 1'b0, ofs, 4'hF, 32'h0);
      end else if (sel < 93) begin
        access("R7 rnd partial", 1'($urandom), 4'h4, 4'($urandom_range(0, 14)), $urandom);
      end else begin
        ofs = 4'($urandom_range(0, 15));
        if (ofs == 4'h0 || ofs == 4'h4 || ofs == 4'hC) ofs = 4'h8;
        access("R8 rnd other offset", 1'b1, ofs, 4'hF, $urandom);
      end
      look("R3 rnd", 8'($urandom), 2'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule